// File: doc/BRIEF.md
# Stereo Zero-Run Automute and Soft-Mute Gain Controller

This block sits in a stereo PCM sample path ahead of the interpolation filters. Each strobed sample pair is multiplied by a shared gain and registered to the output. A three-level mute selector decides whether that gain glides down towards zero or back up towards unity. The steps are taken once per sample, so muting fades the signal rather than cutting it off.

The block also watches for silence on its own. It counts consecutive sample pairs in which both channels are exactly zero. Once the run is long enough it sets an automute latch, and one non-zero sample on either channel clears that latch again. The latch is always visible as a status output. It causes muting only when the selector is in its floating setting: a forced-low selector overrides it, and a forced-high selector mutes regardless.

Top module: `zmute_ctrl`

## Requirements
- R1: After reset, out_valid, out_left, out_right and automuted are all 0, and the gain is unity, so the first sample passes unchanged.
- R2: out_valid equals in_valid delayed by one clock. On a clock with in_valid low, out_left and out_right hold their previous values.
- R3: While the gain is unity (1024), each output sample equals its input sample exactly.
- R4: For each valid sample, out = floor((sample * g + 512) / 1024), with signed arithmetic, where g is the gain held before that sample's clock edge.
- R5: On each valid sample with mute requested, the gain drops by 1 and saturates at 0. While the gain is 0, both outputs are exactly 0.
- R6: On each valid sample without a mute request, the gain rises by 1 and saturates at 1024.
- R7: mute_sel encoding: 2'b00 = low, never mute, even while automuted is set. 2'b01 and 2'b11 = high, always mute. 2'b10 = floating, mute exactly when automuted was set before the sample.
- R8: automuted rises at the clock edge of the 1024th consecutive valid sample in which both channels are zero, and not earlier. It is tracked under every mute_sel setting.
- R9: A valid sample with a non-zero left or right value clears automuted at that edge and restarts the zero run from zero.
- R10: The zero-run count saturates instead of wrapping, so automuted stays set through any longer run of zero samples.
- R11: Clocks without in_valid change neither the gain, the zero run nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| mute_sel | input | 2 | Mute selector: 00 low, 01/11 high, 10 floating |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Gain-scaled left sample |
| out_right | output | 24 | Gain-scaled right sample |
| automuted | output | 1 | Zero-run automute latch status |

## Verification
A wrong gain value appears on the very next valid output sample as a mismatch against the rounded product. An error in step direction or saturation grows by one LSB of gain per sample, so it shows within a few samples of a ramp. A zero-run counter that is off by one moves the automuted edge by one sample, which is caught by checking the flag at the 1023rd and 1024th zero sample. A latch that fails to clear is caught on the first non-zero sample, and a counter that wraps drops the flag partway through a long silence.

// File: rtl/zmute_pkg.sv
package zmute_pkg;

   typedef enum logic [1:0] {
      MSEL_LOW      = 2'b00,
      MSEL_HIGH     = 2'b01,
      MSEL_FLOAT    = 2'b10,
      MSEL_HIGH_ALT = 2'b11
   } msel_e;

   // Mute priority: low overrides the latch, high forces, floating defers to the latch.
   function automatic logic mute_request(input msel_e sel, input logic latch);
      case (sel)
         MSEL_LOW:   return 1'b0;
         MSEL_FLOAT: return latch;
         default:    return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/zmute_zero_run.sv
module zmute_zero_run #(
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   output logic                latch_q
);
   localparam int CNT_W = $clog2(RUN_LEN) + 1;
   localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(RUN_LEN);
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("zmute_zero_run: RUN_LEN must be at least 2");
   end

   logic [CNT_W-1:0] run_q;
   logic             both_zero;

   assign both_zero = (smp_left == '0) && (smp_right == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         latch_q <= 1'b0;
      end else if (smp_valid) begin
         if (both_zero) begin
            if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
            if (run_q >= RUN_LAST) latch_q <= 1'b1;
         end else begin
            run_q   <= '0;
            latch_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/zmute_gain_ramp.sv
module zmute_gain_ramp #(
   parameter int GAIN_W = 10,
   parameter int STEP   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            smp_valid,
   input  logic            mute_req,
   output logic [GAIN_W:0] gain_q
);
   localparam int GW1 = GAIN_W + 1;
   localparam logic [GAIN_W:0] UNITY  = GW1'(1) << GAIN_W;
   localparam logic [GAIN_W:0] STEP_V = GW1'(STEP);
   localparam logic [GAIN_W:0] UP_LIM = UNITY - STEP_V;

   if (STEP < 1 || STEP > (1 << GAIN_W)) begin : g_bad_step
      $error("zmute_gain_ramp: STEP out of range");
   end

   logic [GAIN_W:0] gain_d;

   always_comb begin
      if (mute_req) gain_d = (gain_q > STEP_V) ? gain_q - STEP_V : '0;
      else          gain_d = (gain_q >= UP_LIM) ? UNITY : gain_q + STEP_V;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gain_q <= UNITY;
      else if (smp_valid) gain_q <= gain_d;
   end

endmodule

// File: rtl/zmute_scale.sv
module zmute_scale #(
   parameter int SAMPLE_W = 24,
   parameter int GAIN_W   = 10,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic [SAMPLE_W-1:0] smp_in,
   input  logic [GAIN_W:0]     gain,
   output logic [SAMPLE_W-1:0] smp_out
);
   localparam int PW = SAMPLE_W + GAIN_W + 2;

   logic signed [PW-1:0] s_ext, g_ext, prod, biased;

   assign s_ext = {{(GAIN_W + 2){smp_in[SAMPLE_W-1]}}, smp_in};
   assign g_ext = {{(SAMPLE_W + 1){1'b0}}, gain};
   assign prod  = s_ext * g_ext;

   if (ROUND_EN) begin : g_round
      localparam logic signed [PW-1:0] HALF = {{(PW - GAIN_W){1'b0}}, 1'b1, {(GAIN_W - 1){1'b0}}};
      assign biased = prod + HALF;
   end else begin : g_trunc
      assign biased = prod;
   end

   assign smp_out = biased[GAIN_W +: SAMPLE_W];

endmodule

// File: rtl/zmute_ctrl.sv
module zmute_ctrl
   import zmute_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int GAIN_W   = 10,
   parameter int STEP     = 1,
   parameter int RUN_LEN  = 1024,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic [1:0]          mute_sel,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_left,
   output logic [SAMPLE_W-1:0] out_right,
   output logic                automuted
);
   localparam int NCH = 2;

   if (SAMPLE_W < 8 || GAIN_W < 2) begin : g_bad_width
      $error("zmute_ctrl: SAMPLE_W or GAIN_W too small");
   end

   logic            mute_req;
   logic [GAIN_W:0] gain;
   logic [SAMPLE_W-1:0] ch_in  [NCH];
   logic [SAMPLE_W-1:0] ch_out [NCH];
   logic [SAMPLE_W-1:0] ch_q   [NCH];

   assign mute_req = mute_request(msel_e'(mute_sel), automuted);

   zmute_zero_run #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_zero (
      .clk(clk), .rst_n(rst_n), .smp_valid(in_valid),
      .smp_left(in_left), .smp_right(in_right), .latch_q(automuted));

   zmute_gain_ramp #(.GAIN_W(GAIN_W), .STEP(STEP)) u_ramp (
      .clk(clk), .rst_n(rst_n), .smp_valid(in_valid),
      .mute_req(mute_req), .gain_q(gain));

   assign ch_in[0] = in_left;
   assign ch_in[1] = in_right;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      zmute_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .ROUND_EN(ROUND_EN)) u_scale (
         .smp_in(ch_in[c]), .gain(gain), .smp_out(ch_out[c]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ch_q[c] <= '0;
         else if (in_valid) ch_q[c] <= ch_out[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   assign out_left  = ch_q[0];
   assign out_right = ch_q[1];

endmodule

// File: rtl/zmute_ctrl_chk.sv
module zmute_ctrl_chk #(
   parameter int SAMPLE_W = 24,
   parameter int GAIN_W   = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [SAMPLE_W-1:0] in_left,
   input logic [SAMPLE_W-1:0] in_right,
   input logic [1:0]          mute_sel,
   input logic                out_valid,
   input logic [SAMPLE_W-1:0] out_left,
   input logic [SAMPLE_W-1:0] out_right,
   input logic                automuted,
   input logic [GAIN_W:0]     gain
);
   localparam logic [GAIN_W:0] UNITY = (GAIN_W + 1)'(1) << GAIN_W;

   p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_left) && $stable(out_right)));
   p_gain_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gain <= UNITY);
   p_zero_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gain == '0) |=> (out_left == '0 && out_right == '0));
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_left != '0 || in_right != '0)) |=> !automuted);
   p_low_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mute_sel == 2'b00 && gain < UNITY) |=> gain > $past(gain));
   p_high_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mute_sel[0] && gain != '0) |=> gain < $past(gain));
   p_idle_gain_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(gain) && $stable(automuted)));

endmodule

bind zmute_ctrl zmute_ctrl_chk #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
   .in_right(in_right), .mute_sel(mute_sel), .out_valid(out_valid),
   .out_left(out_left), .out_right(out_right), .automuted(automuted),
   .gain(gain));

// File: tb/zmute_ctrl_test.sv
`timescale 1ns/1ps
module zmute_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_left = '0, in_right = '0;
   logic [1:0]  mute_sel = 2'b00;
   logic        out_valid, automuted;
   logic [23:0] out_left, out_right;

   int checks = 0, errors = 0;
   int m_gain = 1024, m_run = 0;
   bit m_lat = 1'b0;
   logic [23:0] m_ol = '0, m_or = '0;

   always #10 clk = ~clk;

   zmute_ctrl uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
      .in_right(in_right), .mute_sel(mute_sel), .out_valid(out_valid),
      .out_left(out_left), .out_right(out_right), .automuted(automuted));

   function automatic logic [23:0] scale(input logic [23:0] s, input int g);
      longint p;
      p = longint'($signed(s)) * longint'(g) + 64'sd512;
      return 24'(p >>> 10);
   endfunction

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic put(input string tag, input logic [23:0] l, input logic [23:0] r,
                      input bit v, input logic [1:0] sel);
      bit req;
      @(negedge clk);
      in_valid = v; in_left = l; in_right = r; mute_sel = sel;
      req = (sel == 2'b01) || (sel == 2'b11) || (sel == 2'b10 && m_lat);
      if (v) begin
         m_ol = scale(l, m_gain);
         m_or = scale(r, m_gain);
         if (req) m_gain = (m_gain > 1) ? m_gain - 1 : 0;
         else     m_gain = (m_gain >= 1023) ? 1024 : m_gain + 1;
         if (l == 0 && r == 0) begin
            if (m_run < 1024) m_run++;
            if (m_run >= 1024) m_lat = 1'b1;
         end else begin
            m_run = 0; m_lat = 1'b0;
         end
      end
      @(posedge clk);
      #5;
      check(tag, "out_valid", out_valid, v);
      check(tag, "out_left", out_left, m_ol);
      check(tag, "out_right", out_right, m_or);
      check(tag, "automuted", automuted, m_lat);
   endtask

   function automatic logic [23:0] rnd_nz();
      logic [23:0] x;
      x = 24'($urandom);
      return (x == 0) ? 24'h1 : x;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #5;
      // R1: reset state
      check("R1", "out_valid", out_valid, 0);
      check("R1", "out_left", out_left, 0);
      check("R1", "automuted", automuted, 0);
      @(negedge clk); rst_n = 1'b1;
      // R1, R3: unity gain passes samples unchanged
      put("R1", 24'h7FFFFF, 24'h800000, 1'b1, 2'b00);
      for (int i = 0; i < 200; i++) put("R3", rnd_nz(), rnd_nz(), 1'b1, 2'b00);
      // R5, R2, R11: forced mute with gaps in the strobe
      for (int i = 0; i < 1500; i++)
         put(($urandom_range(0, 3) == 0) ? "R11" : "R5", rnd_nz(), rnd_nz(),
             $urandom_range(0, 3) != 0, 2'b01);
      // R5: fully muted output is zero for extreme values
      put("R5", 24'h7FFFFF, 24'h800000, 1'b1, 2'b01);
      // R6, R4: ramp back up with random samples
      for (int i = 0; i < 1100; i++) put("R6", rnd_nz(), rnd_nz(), 1'b1, 2'b00);
      // R4: partial gain with rounding on odd values
      for (int i = 0; i < 300; i++) put("R4", rnd_nz(), 24'($urandom_range(0, 3)), 1'b1, 2'b11);
      for (int i = 0; i < 1100; i++) put("R4", rnd_nz(), rnd_nz(), 1'b1, 2'b00);
      // R8: zero run in floating mode, edge at the 1024th sample
      for (int i = 0; i < 1023; i++) put("R8", 24'h0, 24'h0, 1'b1, 2'b10);
      check("R8", "flag before 1024th", automuted, 0);
      put("R8", 24'h0, 24'h0, 1'b1, 2'b10);
      check("R8", "flag after 1024th", automuted, 1);
      for (int i = 0; i < 1100; i++) put("R8", 24'h0, 24'h0, 1'b1, 2'b10);
      // R9: single non-zero sample on the right clears the latch
      put("R9", 24'h0, 24'h000100, 1'b1, 2'b10);
      check("R9", "flag cleared", automuted, 0);
      for (int i = 0; i < 600; i++) put("R9", 24'h0, 24'h0, 1'b1, 2'b10);
      put("R9", 24'h000001, 24'h0, 1'b1, 2'b10);
      // R10: long silence keeps the flag set
      for (int i = 0; i < 5000; i++) put("R10", 24'h0, 24'h0, 1'b1, 2'b10);
      check("R10", "flag held", automuted, 1);
      // R7: low selector overrides a set latch, gain returns to unity
      for (int i = 0; i < 1100; i++) put("R7", 24'h0, 24'h0, 1'b1, 2'b00);
      put("R7", 24'h123456, 24'hFEDCBA, 1'b1, 2'b00);
      check("R7", "latch clears on data", automuted, 0);
      for (int i = 0; i < 200; i++) put("R7", rnd_nz(), rnd_nz(), 1'b1, 2'b11);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #3000000;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule